// File: doc/BRIEF.md
# I2C Byte-Addressed EEPROM Target

This block is a synthesizable I2C target that behaves like a small serial EEPROM. It has a 256-byte store and a one-byte address pointer. The block runs from a fast system clock and oversamples the bus. Tristate pads are not used, so the bus appears as three plain signals. `scl_i` and `sda_i` carry the controller's levels. `sda_o` is the target's own SDA drive, where 1 means the line is released.

A write transfer works as follows:
- A device-address byte with bit 0 clear selects a write.
- The first byte after it loads the address pointer.
- Every later byte is stored at the pointer, and the pointer then advances.

A device-address byte with bit 0 set selects a read. The target then streams bytes from the pointer until the controller ends the transfer with START or STOP. The pointer is kept across transfers. Writing a pointer and then issuing a repeated START with a read therefore gives a random read.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, `sda_o` is 1, the pointer is 0 and the store location i holds the value i.
- R2: SDA falling while SCL is high is a START. It restarts reception of a device-address byte with an empty bit count, even in the middle of a byte.
- R3: SDA rising while SCL is high is a STOP. It puts the target in idle with `sda_o` = 1.
- R4: Received bytes are taken MSB first, one bit on each SCL rising edge. After the eighth bit, `sda_o` goes low at the next SCL falling edge and is released at the SCL falling edge after that.
- R5: In the device-address byte, bits [3:1] must equal the `DEV_SEL` parameter. On a mismatch the byte is still acknowledged. The target then goes idle and ignores everything until the next START: it gives no acknowledge and makes no store or pointer change.
- R6: When device-address bit 0 is 1, the target loads the byte at the pointer and increments the pointer modulo 256. It then drives that byte MSB first, changing `sda_o` on each SCL rising edge.
- R7: When device-address bit 0 is 0, the next byte loads the pointer. Each further byte is stored at the pointer, and the pointer is then incremented modulo 256.
- R8: After the eighth data bit of a read, the target treats the next SCL rising edge as the controller's acknowledge slot. At that edge it loads the next byte from the pointer and increments the pointer, whatever the acknowledge level. This means a read of N bytes advances the pointer by N+1.
- R9: The pointer is not changed by START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level from the controller |
| sda_i | input | 1 | SDA level driven by the controller |
| sda_o | output | 1 | Target SDA drive, 1 = released, 0 = pulled low |

## Verification
Each bus edge passes through two synchronizer flops and is then compared with its previous sample. A reaction on `sda_o` (an acknowledge edge, a data bit or a release) therefore appears on the third system-clock edge after the input change. The bench changes `scl_i` and `sda_i` only on falling clock edges. It then holds each level for eight clock cycles and samples `sda_o` at the end of that hold, well past the three-cycle latency and before the next bus change. Stored contents are checked only at the bus, by reading them back. Each expected byte is taken from a bench model of the store and pointer. The model is updated at the points where R6, R7 and R8 say the pointer moves.

// File: rtl/eeprom_tgt_pkg.sv
package eeprom_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_TX,
    ST_CHK
  } tgt_state_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_PTR,
    PH_WDATA,
    PH_RDATA
  } tgt_phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sr <= '1;
          sda_sr <= '1;
        end else begin
          scl_sr <= scl_i;
          sda_sr <= sda_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sr <= '1;
          sda_sr <= '1;
        end else begin
          scl_sr <= {scl_sr[STAGES-2:0], scl_i};
          sda_sr <= {sda_sr[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_sr[STAGES-1];
      sda_q <= sda_sr[STAGES-1];
    end
  end

  assign scl_o      = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // START/STOP only while SCL is steadily high
  assign start_o    = ~sda_o & sda_q & scl_o & scl_q;
  assign stop_o     = sda_o & ~sda_q & scl_o & scl_q;
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DATA_W'(i);
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eeprom_tgt_pkg::*;
#(
  parameter logic [2:0] DEV_SEL     = 3'b000,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o
);
  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_w),
    .stop_o    (stop_w)
  );

  tgt_state_e        state_q;
  tgt_phase_e        phase_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] rx_q, tx_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              sda_q;
  logic              mem_we;
  logic [DATA_W-1:0] mem_rdata;

  // store happens on the release edge of the acknowledge in write-data phase
  assign mem_we = !start_w && !stop_w && (state_q == ST_ACK_HI) && scl_fall
                  && (phase_q == PH_WDATA);

  eeprom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mem_we),
    .addr_i (ptr_q),
    .wdata_i(rx_q),
    .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_DEV;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      sda_q     <= 1'b1;
    end else if (start_w) begin
      state_q   <= ST_RX;
      phase_q   <= PH_DEV;
      bit_cnt_q <= '0;
      sda_q     <= 1'b1;
    end else if (stop_w) begin
      state_q <= ST_IDLE;
      phase_q <= PH_DEV;
      sda_q   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: sda_q <= 1'b1;
        ST_RX: if (scl_rise) begin
          rx_q      <= {rx_q[DATA_W-2:0], sda_s};
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == CNT_W'(DATA_W - 1)) state_q <= ST_ACK_LO;
        end
        ST_ACK_LO: if (scl_fall) begin
          sda_q   <= 1'b0;
          state_q <= ST_ACK_HI;
        end
        ST_ACK_HI: if (scl_fall) begin
          sda_q <= 1'b1;
          unique case (phase_q)
            PH_DEV: begin
              if (rx_q[3:1] != DEV_SEL) begin
                state_q <= ST_IDLE;
              end else if (rx_q[0]) begin
                phase_q <= PH_RDATA;
                tx_q    <= mem_rdata;
                ptr_q   <= ptr_q + 1'b1;
                state_q <= ST_TX;
              end else begin
                phase_q <= PH_PTR;
                state_q <= ST_RX;
              end
            end
            PH_PTR: begin
              ptr_q   <= rx_q[ADDR_W-1:0];
              phase_q <= PH_WDATA;
              state_q <= ST_RX;
            end
            PH_WDATA: begin
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_RX;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
        ST_TX: if (scl_rise) begin
          sda_q     <= tx_q[DATA_W-1];
          tx_q      <= {tx_q[DATA_W-2:0], 1'b0};
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == CNT_W'(DATA_W - 1)) state_q <= ST_CHK;
        end
        ST_CHK: if (scl_rise) begin
          // controller acknowledge level is not consulted
          tx_q    <= mem_rdata;
          ptr_q   <= ptr_q + 1'b1;
          state_q <= ST_TX;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sda_o = sda_q;

  a_r2_start_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> (state_q == ST_RX) && (bit_cnt_q == '0) && (phase_q == PH_DEV));

  a_r3_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> (state_q == ST_IDLE) && sda_o);

  a_r4_low_only_ack_or_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sda_o |-> (state_q == ST_ACK_HI) || (state_q == ST_TX) || (state_q == ST_CHK));

  a_r5_mismatch_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK_HI && scl_fall && !start_w && !stop_w && phase_q == PH_DEV
     && rx_q[3:1] != DEV_SEL) |=> (state_q == ST_IDLE) && sda_o);

  a_r7_ptr_step_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> ptr_q == $past(ptr_q) + ADDR_W'(1));

  a_r8_ptr_step_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHK && scl_rise && !start_w && !stop_w)
    |=> (state_q == ST_TX) && (ptr_q == $past(ptr_q) + ADDR_W'(1)));

  a_r9_ptr_kept_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_w || stop_w) |=> $stable(ptr_q));
endmodule

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_i = 1'b1;
  logic sda_i = 1'b1;
  logic sda_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] mdl [256];
  int mptr = 0;
  logic [7:0] exp_tx = '0;

  localparam logic [2:0] SEL = 3'b000;

  always #4 clk_i = ~clk_i;

  i2c_eeprom_target i_i2c_eeprom_target (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .sda_o (sda_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (8) @(negedge clk_i);
  endtask

  task automatic bus_start();
    sda_i = 1'b1; hp(); scl_i = 1'b1; hp(); sda_i = 1'b0; hp(); scl_i = 1'b0; hp();
  endtask

  task automatic bus_stop(input string req);
    sda_i = 1'b0; hp(); scl_i = 1'b1; hp(); sda_i = 1'b1; hp();
    chk(sda_o == 1'b1, req, sda_o, 1);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_i = b[i]; hp(); scl_i = 1'b1; hp(); scl_i = 1'b0; hp();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic e;
    e = exp_ack ? 1'b0 : 1'b1;
    send_bits(b, 8);
    sda_i = 1'b1; hp();
    chk(sda_o == e, req, sda_o, e);
    scl_i = 1'b1; hp();
    chk(sda_o == e, req, sda_o, e);
    scl_i = 1'b0; hp();
    chk(sda_o == 1'b1, req, sda_o, 1);
  endtask

  task automatic recv_byte(input bit ack, input string req);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      scl_i = 1'b1; hp(); b[i] = sda_o; scl_i = 1'b0; hp();
    end
    chk(b == exp_tx, req, b, exp_tx);
    sda_i = ack ? 1'b0 : 1'b1; hp(); scl_i = 1'b1; hp(); scl_i = 1'b0; hp();
    sda_i = 1'b1; hp();
    exp_tx = mdl[mptr]; mptr = (mptr + 1) % 256;
  endtask

  function automatic logic [7:0] dev_byte(input logic [2:0] sel, input bit rd);
    return {4'b1010, sel, rd};
  endfunction

  task automatic start_read(input string req);
    bus_start();
    send_byte(dev_byte(SEL, 1'b1), 1'b1, req);
    exp_tx = mdl[mptr]; mptr = (mptr + 1) % 256;
  endtask

  task automatic write_burst(input int addr, input int n, input string req);
    logic [7:0] d;
    bus_start();
    send_byte(dev_byte(SEL, 1'b0), 1'b1, req);
    send_byte(8'(addr), 1'b1, req);
    mptr = addr;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, 1'b1, req);
      mdl[mptr] = d; mptr = (mptr + 1) % 256;
    end
    bus_stop("R3");
  endtask

  task automatic random_read(input int addr, input int n, input string req);
    bus_start();
    send_byte(dev_byte(SEL, 1'b0), 1'b1, req);
    send_byte(8'(addr), 1'b1, req);
    mptr = addr;
    start_read(req);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, req);
    bus_stop("R3");
  endtask

  initial begin
    int a, n;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) mdl[i] = 8'(i);
    repeat (4) @(negedge clk_i);
    chk(sda_o == 1'b1, "R1", sda_o, 1);
    rst_ni = 1'b1;
    hp();
    chk(sda_o == 1'b1, "R1", sda_o, 1);

    // R1 R6: current-address read from pointer 0 right after reset
    start_read("R6");
    recv_byte(1'b1, "R1");
    recv_byte(1'b1, "R6");
    recv_byte(1'b0, "R6");
    bus_stop("R3");

    // R8: read keeps going after a missing acknowledge
    start_read("R8");
    recv_byte(1'b0, "R8");
    recv_byte(1'b0, "R8");
    bus_stop("R3");

    // R7: write burst wrapping past the top of the store
    write_burst(254, 4, "R7");
    random_read(254, 4, "R7");
    // R9: pointer kept across STOP, current-address read continues
    start_read("R9");
    recv_byte(1'b0, "R9");
    bus_stop("R9");

    // R5: mismatched select acked, then ignored
    bus_start();
    send_byte(dev_byte(SEL ^ 3'b101, 1'b0), 1'b1, "R5");
    send_byte(8'h10, 1'b0, "R5");
    send_byte(8'hA5, 1'b0, "R5");
    bus_stop("R3");
    start_read("R5");
    recv_byte(1'b0, "R5");
    bus_stop("R3");
    random_read(16, 1, "R5");

    // R2: START in the middle of a pointer byte restarts address reception
    bus_start();
    send_byte(dev_byte(SEL, 1'b0), 1'b1, "R2");
    send_bits(8'hF0, 4);
    start_read("R2");
    recv_byte(1'b1, "R2");
    recv_byte(1'b0, "R2");
    bus_stop("R3");

    // R4 R7: random bursts checked by random reads
    for (int it = 0; it < 10; it++) begin
      a = int'($urandom % 256);
      n = 1 + int'($urandom % 4);
      write_burst(a, n, "R4");
      random_read(a, n, "R7");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule